// File: doc/BRIEF.md
# Dual-Channel Serial Port Interrupt Aggregator

This block collects the interrupt causes of a two-channel serial port and drives one interrupt line per channel. Each channel has four causes. Two of them follow FIFO flags directly, each through a mode-selected multiplexer: one for the transmit side and one for the receive side. The other two are sticky: one catches any change of the received break condition, and one catches any edge on the channel's two handshake inputs (clear-to-send and carrier detect). A cause raises the channel's interrupt only when its mask bit is set.

Software reaches the block through an 8-entry register window. The window has a combined status view and two per-channel status views. It has one mask store, which can be written as a whole or one channel half at a time. It also has a handshake-pin register that shows the current synchronized pin levels and the per-pin change flags; reading it clears the flags. A break register shows the break latches. The serializers, FIFOs and bus decoding sit outside this block.

Top module: `uart_irq_agg`

## Requirements
- R1: Address 0 returns the combined status, with channel A's four status bits in bits 3:0 and channel B's in bits 7:4. Status bit 0 is transmit, bit 1 is receive, bit 2 is break change and bit 3 is handshake change.
- R2: Address 1 returns channel A status and address 2 returns channel B status, each in bits 3:0, with bits 7:4 reading zero.
- R3: The mask store is a single 8-bit register. A write to address 3 loads all 8 bits. A write to address 4 loads bits 3:0 from wdata[3:0], and a write to address 5 loads bits 7:4 from wdata[3:0]. Reads of addresses 3, 4 and 5 return the whole mask, the low nibble and the high nibble respectively. Writes to any other address leave the mask unchanged.
- R4: irq[c] is high exactly when some status bit of channel c is set together with the matching mask bit (mask bits 3:0 for A, 7:4 for B).
- R5: Status bit 0 shows tx_fifo_empty when tx_sel is 1 and tx_ready when tx_sel is 0.
- R6: Status bit 1 shows rx_fifo_full when rx_sel is 1 and rx_fifo_nempty when rx_sel is 0.
- R7: The break latch of a channel is set one clock after rx_break changes level in either direction. It is cleared by break_reset, and a change in the same cycle wins over the clear. Address 7 returns the latches in bit 0 (A) and bit 1 (B), with the other bits zero. Each latch is status bit 2 of its channel.
- R8: Status bit 3 of a channel is set when either of its handshake inputs changes. It is cleared by a read of address 6, unless a change arrives in that same cycle.
- R9: Address 6 returns the synchronized levels in bits 0 (A clear-to-send), 1 (B clear-to-send), 2 (A carrier) and 3 (B carrier), and the matching change flags in bits 4, 5, 6 and 7. A read (reg_rd high at address 6) clears all flags, except a flag whose pin changes in that same cycle.
- R10: After reset the mask, the break latches, the change flags and the handshake status latches are zero, so irq is low.
- R11: A handshake pin change shows in the level bits SYNC_STAGES clocks after it is applied, and in the change flag one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_fifo_empty | input | 2 | Per-channel transmit FIFO empty flag |
| tx_ready | input | 2 | Per-channel transmitter ready flag |
| rx_fifo_full | input | 2 | Per-channel receive FIFO full flag |
| rx_fifo_nempty | input | 2 | Per-channel receive FIFO not-empty flag |
| tx_sel | input | 2 | Per-channel transmit source select (1 = FIFO empty) |
| rx_sel | input | 2 | Per-channel receive source select (1 = FIFO full) |
| rx_break | input | 2 | Per-channel raw received break level |
| break_reset | input | 2 | Per-channel clear command for the break latch |
| cts_in | input | 2 | Per-channel clear-to-send pin, asynchronous |
| dcd_in | input | 2 | Per-channel carrier-detect pin, asynchronous |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (only address 6 has a side effect) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from reg_addr |
| irq | output | 2 | Per-channel interrupt |

## Verification
The bench builds the block with its default SYNC_STAGES of 2, so the exact cycle of every handshake flag is known. A read can then be aimed at the same cycle as a pin change. The two channels and four FIFO flags per channel make the source space small, so the bench walks all 4096 combinations of select bits and flags and checks every status view. It also walks all 256 mask values against a fixed status pattern.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int CH_N   = 2;
    localparam int NIB_W  = 4;
    localparam int REG_W  = CH_N * NIB_W;
    localparam int ADDR_W = 3;
    localparam int PIN_N  = 2 * CH_N;

    localparam int ST_TX  = 0;
    localparam int ST_RX  = 1;
    localparam int ST_BRK = 2;
    localparam int ST_PIN = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_STAT   = 3'd0,
        RA_STAT_A = 3'd1,
        RA_STAT_B = 3'd2,
        RA_MASK   = 3'd3,
        RA_MASK_A = 3'd4,
        RA_MASK_B = 3'd5,
        RA_PINS   = 3'd6,
        RA_BRK    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic tx_empty;
        logic tx_ready;
        logic rx_full;
        logic rx_nempty;
    } fifo_flags_t;

    typedef struct packed {
        logic tx_sel;
        logic rx_sel;
    } src_mode_t;

    // bit 1 = receive cause, bit 0 = transmit cause
    function automatic logic [1:0] pick_ready(fifo_flags_t f, src_mode_t m);
        logic tx_bit;
        logic rx_bit;
        tx_bit = m.tx_sel ? f.tx_empty : f.tx_ready;
        rx_bit = m.rx_sel ? f.rx_full  : f.rx_nempty;
        return {rx_bit, tx_bit};
    endfunction

endpackage

// File: rtl/irq_pin_watch.sv
module irq_pin_watch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic clr,
    output logic level,
    output logic chg,
    output logic flag
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            sync_q[0] <= pin;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            prev_q <= sync_q[SYNC_STAGES-1];
            flag_q <= chg | (flag_q & ~clr);
        end
    end

    assign level = sync_q[SYNC_STAGES-1];
    assign chg   = level ^ prev_q;
    assign flag  = flag_q;

endmodule

// File: rtl/irq_chan.sv
module irq_chan
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fifo_flags_t       flags,
    input  src_mode_t         mode,
    input  logic              brk_raw,
    input  logic              brk_clr,
    input  logic [1:0]        pin_chg,
    input  logic              pins_read,
    output logic [NIB_W-1:0]  status,
    output logic              brk_chg,
    output logic              brk_lat
);
    logic brk_q;
    logic brk_lat_q;
    logic pin_lat_q;
    logic any_pin_chg;

    assign brk_chg     = brk_raw ^ brk_q;
    assign any_pin_chg = |pin_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q     <= 1'b0;
            brk_lat_q <= 1'b0;
            pin_lat_q <= 1'b0;
        end else begin
            brk_q <= brk_raw;
            if (brk_chg) begin
                brk_lat_q <= 1'b1;
            end else if (brk_clr) begin
                brk_lat_q <= 1'b0;
            end
            if (any_pin_chg) begin
                pin_lat_q <= 1'b1;
            end else if (pins_read) begin
                pin_lat_q <= 1'b0;
            end
        end
    end

    logic [1:0] ready_bits;
    assign ready_bits = pick_ready(flags, mode);

    always_comb begin
        status         = '0;
        status[ST_TX]  = ready_bits[0];
        status[ST_RX]  = ready_bits[1];
        status[ST_BRK] = brk_lat_q;
        status[ST_PIN] = pin_lat_q;
    end

    assign brk_lat = brk_lat_q;

endmodule

// File: rtl/irq_regs.sv
module irq_regs
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [REG_W-1:0]  wdata,
    input  logic [NIB_W-1:0]  stat_a,
    input  logic [NIB_W-1:0]  stat_b,
    input  logic [REG_W-1:0]  pins_view,
    input  logic [CH_N-1:0]   brk_view,
    output logic [REG_W-1:0]  rdata,
    output logic [REG_W-1:0]  mask,
    output logic              pins_clr
);
    reg_sel_e          sel;
    logic [REG_W-1:0]  mask_q;

    assign sel = reg_sel_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wr) begin
            case (sel)
                RA_MASK:   mask_q                <= wdata;
                RA_MASK_A: mask_q[NIB_W-1:0]     <= wdata[NIB_W-1:0];
                RA_MASK_B: mask_q[REG_W-1:NIB_W] <= wdata[NIB_W-1:0];
                default:   mask_q                <= mask_q;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            RA_STAT:   rdata = {stat_b, stat_a};
            RA_STAT_A: rdata[NIB_W-1:0] = stat_a;
            RA_STAT_B: rdata[NIB_W-1:0] = stat_b;
            RA_MASK:   rdata = mask_q;
            RA_MASK_A: rdata[NIB_W-1:0] = mask_q[NIB_W-1:0];
            RA_MASK_B: rdata[NIB_W-1:0] = mask_q[REG_W-1:NIB_W];
            RA_PINS:   rdata = pins_view;
            RA_BRK:    rdata[CH_N-1:0] = brk_view;
            default:   rdata = '0;
        endcase
    end

    assign mask     = mask_q;
    assign pins_clr = rd && (sel == RA_PINS);

endmodule

// File: rtl/uart_irq_agg.sv
module uart_irq_agg
    import uart_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        tx_fifo_empty,
    input  logic [1:0]        tx_ready,
    input  logic [1:0]        rx_fifo_full,
    input  logic [1:0]        rx_fifo_nempty,
    input  logic [1:0]        tx_sel,
    input  logic [1:0]        rx_sel,
    input  logic [1:0]        rx_break,
    input  logic [1:0]        break_reset,
    input  logic [1:0]        cts_in,
    input  logic [1:0]        dcd_in,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [1:0]        irq
);
    // pin index: 0 = A cts, 1 = B cts, 2 = A dcd, 3 = B dcd
    logic [PIN_N-1:0] pin_in;
    logic [PIN_N-1:0] pin_level;
    logic [PIN_N-1:0] pin_chg;
    logic [PIN_N-1:0] pin_flags;
    logic             pins_clr;
    logic [REG_W-1:0] mask_q;
    logic [CH_N-1:0]  brk_chg;
    logic [CH_N-1:0]  brk_lat;
    logic [CH_N-1:0]  pin_stat;
    logic [NIB_W-1:0] chan_stat [CH_N];

    assign pin_in = {dcd_in, cts_in};

    generate
        for (genvar p = 0; p < PIN_N; p++) begin : g_pin
            irq_pin_watch #(.SYNC_STAGES(SYNC_STAGES)) watch_i (
                .clk   (clk),
                .rst   (rst),
                .pin   (pin_in[p]),
                .clr   (pins_clr),
                .level (pin_level[p]),
                .chg   (pin_chg[p]),
                .flag  (pin_flags[p])
            );
        end

        for (genvar c = 0; c < CH_N; c++) begin : g_ch
            fifo_flags_t ff;
            src_mode_t   md;
            assign ff.tx_empty  = tx_fifo_empty[c];
            assign ff.tx_ready  = tx_ready[c];
            assign ff.rx_full   = rx_fifo_full[c];
            assign ff.rx_nempty = rx_fifo_nempty[c];
            assign md.tx_sel    = tx_sel[c];
            assign md.rx_sel    = rx_sel[c];

            irq_chan chan_i (
                .clk       (clk),
                .rst       (rst),
                .flags     (ff),
                .mode      (md),
                .brk_raw   (rx_break[c]),
                .brk_clr   (break_reset[c]),
                .pin_chg   ({pin_chg[CH_N + c], pin_chg[c]}),
                .pins_read (pins_clr),
                .status    (chan_stat[c]),
                .brk_chg   (brk_chg[c]),
                .brk_lat   (brk_lat[c])
            );

            assign pin_stat[c] = chan_stat[c][ST_PIN];
            assign irq[c] = |(chan_stat[c] & mask_q[c*NIB_W +: NIB_W]);
        end
    endgenerate

    irq_regs regs_i (
        .clk       (clk),
        .rst       (rst),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .wdata     (reg_wdata),
        .stat_a    (chan_stat[0]),
        .stat_b    (chan_stat[1]),
        .pins_view ({pin_flags, pin_level}),
        .brk_view  (brk_lat),
        .rdata     (reg_rdata),
        .mask      (mask_q),
        .pins_clr  (pins_clr)
    );

endmodule

// File: rtl/uart_irq_agg_chk.sv
module uart_irq_agg_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [1:0] irq,
    input logic [1:0] break_reset,
    input logic [1:0] brk_chg,
    input logic [1:0] brk_lat,
    input logic [3:0] pin_flags,
    input logic [1:0] pin_stat,
    input logic [7:0] mask_q
);
    p_alias_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 3'd1 || reg_addr == 3'd2) |-> reg_rdata[7:4] == 4'h0);

    p_mask_low_alias_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd4) |=>
            (mask_q[3:0] == $past(reg_wdata[3:0]) && mask_q[7:4] == $past(mask_q[7:4])));

    p_mask_high_alias_r3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd5) |=>
            (mask_q[7:4] == $past(reg_wdata[3:0]) && mask_q[3:0] == $past(mask_q[3:0])));

    p_mask_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!reg_wr || reg_addr < 3'd3 || reg_addr > 3'd5) |=> $stable(mask_q));

    p_irq_needs_mask_r4: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 8'h00) |-> irq == 2'b00);

    p_break_set_a_r7: assert property (@(posedge clk) disable iff (rst)
        brk_chg[0] |=> brk_lat[0]);

    p_break_set_b_r7: assert property (@(posedge clk) disable iff (rst)
        brk_chg[1] |=> brk_lat[1]);

    p_break_clr_a_r7: assert property (@(posedge clk) disable iff (rst)
        (break_reset[0] && !brk_chg[0]) |=> !brk_lat[0]);

    p_break_clr_b_r7: assert property (@(posedge clk) disable iff (rst)
        (break_reset[1] && !brk_chg[1]) |=> !brk_lat[1]);

    p_pin_stat_a_r8: assert property (@(posedge clk) disable iff (rst)
        pin_stat[0] == (pin_flags[0] | pin_flags[2]));

    p_pin_stat_b_r8: assert property (@(posedge clk) disable iff (rst)
        pin_stat[1] == (pin_flags[1] | pin_flags[3]));

    p_flags_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_addr == 3'd6) |=> ((pin_flags & $past(pin_flags)) == $past(pin_flags)));

    p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mask_q == 8'h00 && brk_lat == 2'b00 && pin_flags == 4'h0 && irq == 2'b00));

endmodule

bind uart_irq_agg uart_irq_agg_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .reg_addr    (reg_addr),
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq         (irq),
    .break_reset (break_reset),
    .brk_chg     (brk_chg),
    .brk_lat     (brk_lat),
    .pin_flags   (pin_flags),
    .pin_stat    (pin_stat),
    .mask_q      (mask_q)
);

// File: tb/uart_irq_agg_tb_top.sv
module uart_irq_agg_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] tx_fifo_empty, tx_ready, rx_fifo_full, rx_fifo_nempty;
    logic [1:0] tx_sel, rx_sel, rx_break, break_reset, cts_in, dcd_in;
    logic [2:0] reg_addr;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [1:0] irq;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    uart_irq_agg #(.SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst),
        .tx_fifo_empty(tx_fifo_empty), .tx_ready(tx_ready),
        .rx_fifo_full(rx_fifo_full), .rx_fifo_nempty(rx_fifo_nempty),
        .tx_sel(tx_sel), .rx_sel(rx_sel),
        .rx_break(rx_break), .break_reset(break_reset),
        .cts_in(cts_in), .dcd_in(dcd_in),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rdreg(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wrreg(input logic [2:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick();
        reg_wr    = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rdreg(a, d);
        check(req, d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 8'h0, 8'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [3:0] ea, eb;
        rst = 1'b1;
        tx_fifo_empty = '0; tx_ready = '0; rx_fifo_full = '0; rx_fifo_nempty = '0;
        tx_sel = '0; rx_sel = '0; rx_break = '0; break_reset = '0;
        cts_in = '0; dcd_in = '0;
        reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
        @(negedge clk);
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R10: everything zero after reset
        for (int a = 0; a < 8; a++) expect_reg("R10 reg after reset", 3'(a), 8'h00);
        check("R10 irq after reset", {6'b0, irq}, 8'h00);

        // R1 R2 R4 R5 R6: exhaustive source sweep, mask all ones
        wrreg(3'd3, 8'hFF);
        for (int v = 0; v < 4096; v++) begin
            tx_sel         = v[1:0];
            rx_sel         = v[3:2];
            tx_fifo_empty  = v[5:4];
            tx_ready       = v[7:6];
            rx_fifo_full   = v[9:8];
            rx_fifo_nempty = v[11:10];
            ea = {2'b00, rx_sel[0] ? v[8]  : v[10], tx_sel[0] ? v[4] : v[6]};
            eb = {2'b00, rx_sel[1] ? v[9]  : v[11], tx_sel[1] ? v[5] : v[7]};
            expect_reg("R1 R5 R6 combined status", 3'd0, {eb, ea});
            expect_reg("R2 alias A status", 3'd1, {4'h0, ea});
            expect_reg("R2 alias B status", 3'd2, {4'h0, eb});
            check("R4 irq full mask", {6'b0, irq}, {6'b0, |eb, |ea});
            @(negedge clk);
        end

        // R3: single mask store behind three views
        wrreg(3'd3, 8'h00);
        expect_reg("R3 mask cleared", 3'd3, 8'h00);
        wrreg(3'd4, 8'h05);
        expect_reg("R3 low alias write", 3'd3, 8'h05);
        expect_reg("R3 low alias read", 3'd4, 8'h05);
        expect_reg("R3 high alias read", 3'd5, 8'h00);
        wrreg(3'd5, 8'h0A);
        expect_reg("R3 high alias write", 3'd3, 8'hA5);
        wrreg(3'd4, 8'hF3);
        expect_reg("R3 low alias ignores upper wdata", 3'd3, 8'hA3);
        wrreg(3'd0, 8'hFF);
        wrreg(3'd1, 8'hFF);
        wrreg(3'd6, 8'hFF);
        wrreg(3'd7, 8'hFF);
        expect_reg("R3 other writes ignored", 3'd3, 8'hA3);

        // R4: mask sweep with A status 0011, B status 0001
        tx_sel = '0; rx_sel = '0; tx_fifo_empty = '0; rx_fifo_full = '0;
        tx_ready = 2'b11; rx_fifo_nempty = 2'b01;
        for (int m = 0; m < 256; m++) begin
            wrreg(3'd3, 8'(m));
            check("R4 irq vs mask", {6'b0, irq},
                  {6'b0, |(m[7:4] & 4'b0001), |(m[3:0] & 4'b0011)});
        end
        tx_ready = '0; rx_fifo_nempty = '0;
        wrreg(3'd3, 8'hFF);

        // R7: break latch
        rx_break[0] = 1'b1;
        tick();
        expect_reg("R7 break rise sets A", 3'd7, 8'h01);
        expect_reg("R7 break is status bit 2", 3'd1, 8'h04);
        check("R7 break raises irq", {6'b0, irq}, 8'h01);
        break_reset[0] = 1'b1;
        tick();
        break_reset[0] = 1'b0;
        expect_reg("R7 reset command clears", 3'd7, 8'h00);
        rx_break[0] = 1'b0;
        tick();
        expect_reg("R7 break fall sets A", 3'd7, 8'h01);
        break_reset[0] = 1'b1;
        tick();
        expect_reg("R7 clear again", 3'd7, 8'h00);
        rx_break[0] = 1'b1;
        tick();
        break_reset[0] = 1'b0;
        expect_reg("R7 change beats clear", 3'd7, 8'h01);
        rx_break[1] = 1'b1;
        tick();
        expect_reg("R7 break B latch", 3'd7, 8'h03);
        expect_reg("R7 B alias status", 3'd2, 8'h04);
        expect_reg("R7 combined status", 3'd0, 8'h44);
        break_reset = 2'b11;
        tick();
        break_reset = 2'b00;
        expect_reg("R7 both cleared", 3'd7, 8'h00);
        check("R7 irq drops", {6'b0, irq}, 8'h00);

        // R11 R9 R8: handshake pins
        cts_in[0] = 1'b1;
        tick();
        tick();
        expect_reg("R11 level after sync", 3'd6, 8'h01);
        tick();
        expect_reg("R11 flag one clock later", 3'd6, 8'h11);
        expect_reg("R8 A status bit 3", 3'd1, 8'h08);
        check("R8 irq from pin", {6'b0, irq}, 8'h01);
        dcd_in[1] = 1'b1;
        repeat (3) tick();
        expect_reg("R9 B carrier flag bit 7", 3'd6, 8'h99);
        expect_reg("R8 combined status", 3'd0, 8'h88);
        reg_addr = 3'd6;
        reg_rd   = 1'b1;
        #1;
        check("R9 read shows flags", reg_rdata, 8'h99);
        tick();
        reg_rd = 1'b0;
        expect_reg("R9 read clears flags", 3'd6, 8'h09);
        expect_reg("R8 read clears status", 3'd0, 8'h00);

        cts_in[1] = 1'b1;
        repeat (3) tick();
        expect_reg("R9 B cts flag bit 5", 3'd6, 8'h2B);
        dcd_in[0] = 1'b1;
        tick();
        tick();
        reg_addr = 3'd6;
        reg_rd   = 1'b1;
        tick();
        reg_rd = 1'b0;
        expect_reg("R9 change in read cycle survives", 3'd6, 8'h4F);
        expect_reg("R8 change in read cycle survives", 3'd0, 8'h08);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule